// File: doc/BRIEF.md
# Pulse Arrival Timestamp Capture

This block stamps each pulse of an external pulse stream with its arrival time. A free-running counter advances by one on every cycle in which the timebase tick input is high. With a 100 MHz tick, one count is 10 ns. The pulse input is asynchronous. It passes through a two-stage synchronizer. A two-state edge machine then turns each low-to-high transition into one capture event, which writes the current count into a small FIFO. The FIFO is read through a valid/ready stream.

The edge machine has two states. `CAP_IDLE` means the input is low and the machine is armed. `CAP_HOLD` means a pulse is in progress and the machine is disarmed. The transition `CAP_IDLE -> CAP_HOLD` is taken when the synchronized input is high, and a capture fires on it. The transition `CAP_HOLD -> CAP_IDLE` is taken when the synchronized input is low. Every other case stays in the current state. Two sticky flags report faults, and the clear input resets both. The duplicate flag is set when two captures occur with no count advance between them. The overflow flag is set when a capture finds the FIFO full, in which case the capture is dropped.

Top module: `ts_capture`

## Requirements
- R1: After reset the count is zero, `ts_valid` is low and both `dup_err` and `ovf_err` are low. A capture taken before any tick therefore carries the value 0.
- R2: The count rises by exactly one at each clock edge where `tick` is high and holds where `tick` is low. It wraps from 2^CNT_W-1 to 0, and a wrap never sets any flag.
- R3: A rise of `pulse_in` is seen after two synchronizer flops. The captured value is the count held in the cycle in which the synchronized level is first high. `ts_valid` goes high at the third rising clock edge after `pulse_in` rises, and not before.
- R4: One pulse yields exactly one capture, however long it stays high. The machine re-arms only after the synchronized level has returned low.
- R5: The FIFO returns entries in capture order. An entry is removed at a clock edge where `ts_valid` and `ts_ready` are both high. While `ts_valid` is high and `ts_ready` is low, `ts_data` holds steady.
- R6: A capture that follows an earlier capture with no tick between them sets `dup_err`. A tick in the cycle of the earlier capture counts as between. The first capture after reset never sets it.
- R7: `dup_err` stays set until cleared. Captures continue to be stored while it is set.
- R8: A capture arriving while the FIFO already holds DEPTH (default 8) entries is dropped and sets the sticky `ovf_err`. A pop in that same cycle does not rescue it.
- R9: A high `err_clr` at a clock edge clears both flags. It takes priority over a flag being set at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 1 | Asynchronous pulse stream |
| tick | input | 1 | Timebase tick; count advances when high |
| err_clr | input | 1 | Clears both sticky flags |
| ts_data | output | CNT_W | Oldest stored timestamp |
| ts_valid | output | 1 | FIFO holds at least one entry |
| ts_ready | input | 1 | Consumer accepts `ts_data` |
| dup_err | output | 1 | Sticky: capture without count advance |
| ovf_err | output | 1 | Sticky: capture dropped on full FIFO |

## Verification
The bound checker watches, on every cycle, the properties that do not depend on the stimulus. These are the counter step and hold, the stability of `ts_data` under back-pressure, the stickiness of both flags, the precedence of the clear, and the FIFO level staying within its depth. The directed scenarios cover what needs a known history. They check the exact captured values against a tick model, the three-edge latency, and one capture per wide pulse. They also check that the first capture after reset is exempt from the duplicate flag, that the count wraps without a flag, and that the ninth entry of a full FIFO is absent.

// File: rtl/ts_pkg.sv
package ts_pkg;
    typedef enum logic [0:0] {
        CAP_IDLE = 1'b0,
        CAP_HOLD = 1'b1
    } cap_state_e;

    localparam int unsigned TS_CNT_W_DEF  = 32;
    localparam int unsigned TS_DEPTH_DEF  = 8;
    localparam int unsigned TS_SYNC_DEF   = 2;
endpackage

// File: rtl/ts_sync.sv
module ts_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ts_edge_fsm.sv
module ts_edge_fsm
    import ts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic cap
);
    cap_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE: if (level)  state_d = CAP_HOLD;
            CAP_HOLD: if (!level) state_d = CAP_IDLE;
            default:              state_d = CAP_IDLE;
        endcase
    end

    always_comb begin
        cap = 1'b0;
        unique case (state_q)
            CAP_IDLE: cap = level;
            CAP_HOLD: cap = 1'b0;
            default:  cap = 1'b0;
        endcase
    end
endmodule

// File: rtl/ts_fifo.sv
module ts_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [W-1:0]   din,
    output logic           drop,
    output logic [W-1:0]   dout,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned LW = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [LW-1:0] lvl_q;
    logic          full, acc, pop;

    assign full      = (lvl_q == FULL_LVL);
    assign out_valid = (lvl_q != '0);
    assign acc       = push && !full;
    assign drop      = push && full;
    assign pop       = out_valid && out_ready;
    assign dout      = mem[rd_q];
    assign level     = lvl_q;

    always_ff @(posedge clk) begin
        if (acc) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (acc) wr_q <= (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
            if (pop) rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
            unique case ({acc, pop})
                2'b10:   lvl_q <= lvl_q + 1'b1;
                2'b01:   lvl_q <= lvl_q - 1'b1;
                default: lvl_q <= lvl_q;
            endcase
        end
    end
endmodule

// File: rtl/ts_capture.sv
module ts_capture
    import ts_pkg::*;
#(
    parameter int unsigned CNT_W  = TS_CNT_W_DEF,
    parameter int unsigned DEPTH  = TS_DEPTH_DEF,
    parameter int unsigned STAGES = TS_SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic             tick,
    input  logic             err_clr,
    output logic [CNT_W-1:0] ts_data,
    output logic             ts_valid,
    input  logic             ts_ready,
    output logic             dup_err,
    output logic             ovf_err
);
    localparam int unsigned LW = $clog2(DEPTH + 1);

    logic             sync_lvl;
    logic             cap;
    logic             drop;
    logic [LW-1:0]    fifo_level;
    logic [CNT_W-1:0] cnt_q;
    logic             tick_seen_q;
    logic             have_prev_q;
    logic             dup_set;
    logic             dup_q, ovf_q;

    ts_sync #(.STAGES(STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pulse_in),
        .dout (sync_lvl)
    );

    ts_edge_fsm u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .level(sync_lvl),
        .cap  (cap)
    );

    ts_fifo #(.W(CNT_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (cap),
        .din      (cnt_q),
        .drop     (drop),
        .dout     (ts_data),
        .out_valid(ts_valid),
        .out_ready(ts_ready),
        .level    (fifo_level)
    );

    // free-running timebase counter, wraps silently
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    // duplicate detection: a capture needs a tick since the previous one
    assign dup_set = cap && have_prev_q && !tick_seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_seen_q <= 1'b0;
            have_prev_q <= 1'b0;
        end else if (cap) begin
            tick_seen_q <= tick;
            have_prev_q <= 1'b1;
        end else if (tick) begin
            tick_seen_q <= 1'b1;
        end
    end

    // sticky flags, clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n || err_clr) begin
            dup_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            dup_q <= dup_q | dup_set;
            ovf_q <= ovf_q | drop;
        end
    end

    assign dup_err = dup_q;
    assign ovf_err = ovf_q;
endmodule

// File: rtl/ts_capture_chk.sv
module ts_capture_chk #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned DEPTH = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         tick,
    input logic                         err_clr,
    input logic [CNT_W-1:0]             cnt,
    input logic [CNT_W-1:0]             ts_data,
    input logic                         ts_valid,
    input logic                         ts_ready,
    input logic                         dup_err,
    input logic                         ovf_err,
    input logic [$clog2(DEPTH+1)-1:0]   level
);
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt == $past(cnt) + 1'b1);
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ts_valid && !ts_ready |=> ts_valid && $stable(ts_data));
    // R7
    dup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dup_err && !err_clr |=> dup_err);
    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err && !err_clr |=> ovf_err);
    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> !dup_err && !ovf_err);
    // R8
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind ts_capture ts_capture_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .err_clr (err_clr),
    .cnt     (cnt_q),
    .ts_data (ts_data),
    .ts_valid(ts_valid),
    .ts_ready(ts_ready),
    .dup_err (dup_err),
    .ovf_err (ovf_err),
    .level   (fifo_level)
);

// File: tb/tb_ts_capture.sv
module tb_ts_capture;
    localparam int unsigned CW = 8;
    localparam int unsigned DP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pulse_in = 1'b0;
    logic          tick_en = 1'b0;
    logic          alt_mode = 1'b0;
    logic          phase = 1'b0;
    logic          tick;
    logic          err_clr = 1'b0;
    logic [CW-1:0] ts_data;
    logic          ts_valid;
    logic          ts_ready = 1'b0;
    logic          dup_err, ovf_err;
    logic [CW-1:0] model_cnt;
    int            n_chk = 0;
    int            n_bad = 0;

    always #4 clk = ~clk;

    always @(negedge clk) phase <= ~phase;
    assign tick = alt_mode ? phase : tick_en;

    // tick model: counts clock edges with tick high
    always @(posedge clk) begin
        if (!rst_n)    model_cnt <= '0;
        else if (tick) model_cnt <= model_cnt + 1'b1;
    end

    ts_capture #(.CNT_W(CW), .DEPTH(DP)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_in(pulse_in),
        .tick    (tick),
        .err_clr (err_clr),
        .ts_data (ts_data),
        .ts_valid(ts_valid),
        .ts_ready(ts_ready),
        .dup_err (dup_err),
        .ovf_err (ovf_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pulse_in = 1'b0; err_clr = 1'b0; ts_ready = 1'b0;
        alt_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one pulse; returns the count value it should capture
    task automatic send_pulse(input int hi, input int lo, output logic [CW-1:0] e);
        @(negedge clk);
        pulse_in = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1 e = model_cnt;
        repeat (hi) @(negedge clk);
        pulse_in = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic pop_chk(input logic [CW-1:0] e, input string req);
        @(negedge clk);
        chk(ts_valid === 1'b1, req, int'(ts_valid), 1);
        chk(ts_data === e, req, int'(ts_data), int'(e));
        ts_ready = 1'b1;
        @(negedge clk);
        ts_ready = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic t_reset();
        logic [CW-1:0] e;
        do_reset();
        @(negedge clk);
        chk(ts_valid === 1'b0, "R1 valid", int'(ts_valid), 0);
        chk(dup_err === 1'b0 && ovf_err === 1'b0, "R1 flags", int'({dup_err, ovf_err}), 0);
        tick_en = 1'b0;
        send_pulse(3, 4, e);
        pop_chk(8'd0, "R1 first value");
    endtask

    task automatic t_latency();
        logic [CW-1:0] e;
        do_reset();
        tick_en = 1'b1;
        repeat (5) @(negedge clk);
        pulse_in = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1 e = model_cnt;
        @(negedge clk);
        chk(ts_valid === 1'b0, "R3 not before third edge", int'(ts_valid), 0);
        @(negedge clk);
        chk(ts_valid === 1'b1, "R3 valid at third edge", int'(ts_valid), 1);
        chk(ts_data === e, "R3 value", int'(ts_data), int'(e));
        repeat (4) @(negedge clk);
        chk(ts_data === e, "R5 hold under back-pressure", int'(ts_data), int'(e));
        pulse_in = 1'b0;
        repeat (4) @(negedge clk);
        pop_chk(e, "R3 pop");
        @(negedge clk);
        chk(ts_valid === 1'b0, "R5 empty after pop", int'(ts_valid), 0);
    endtask

    task automatic t_order();
        logic [CW-1:0] e [4];
        do_reset();
        alt_mode = 1'b1;
        for (int i = 0; i < 4; i++) send_pulse(2 + i, 4 + i, e[i]);
        alt_mode = 1'b0;
        for (int i = 0; i < 4; i++) pop_chk(e[i], "R5 order sparse ticks R2");
        chk(dup_err === 1'b0, "R6 no dup when ticks occur", int'(dup_err), 0);
    endtask

    task automatic t_wide();
        logic [CW-1:0] e1, e2;
        do_reset();
        tick_en = 1'b1;
        send_pulse(15, 4, e1);
        pop_chk(e1, "R4 wide pulse value");
        @(negedge clk);
        chk(ts_valid === 1'b0, "R4 single capture", int'(ts_valid), 0);
        send_pulse(2, 4, e2);
        pop_chk(e2, "R4 re-armed");
    endtask

    task automatic t_dup();
        logic [CW-1:0] e1, e2, e3;
        do_reset();
        tick_en = 1'b0;
        send_pulse(2, 4, e1);
        chk(dup_err === 1'b0, "R6 first capture exempt", int'(dup_err), 0);
        send_pulse(2, 4, e2);
        chk(dup_err === 1'b1, "R6 dup set", int'(dup_err), 1);
        tick_en = 1'b1;
        send_pulse(2, 4, e3);
        chk(dup_err === 1'b1, "R7 sticky", int'(dup_err), 1);
        pop_chk(e1, "R7 entry 1");
        pop_chk(e2, "R7 entry 2 stored");
        pop_chk(e3, "R7 entry 3 stored");
        chk(e1 == e2, "R2 hold without tick", int'(e2), int'(e1));
        pulse_clr();
        chk(dup_err === 1'b0, "R9 dup cleared", int'(dup_err), 0);
    endtask

    task automatic t_overflow();
        logic [CW-1:0] e [9];
        do_reset();
        tick_en = 1'b1;
        for (int i = 0; i < 9; i++) send_pulse(2, 4, e[i]);
        chk(ovf_err === 1'b1, "R8 overflow set", int'(ovf_err), 1);
        for (int i = 0; i < 8; i++) pop_chk(e[i], "R8 kept entries");
        @(negedge clk);
        chk(ts_valid === 1'b0, "R8 ninth dropped", int'(ts_valid), 0);
        chk(ovf_err === 1'b1, "R8 sticky", int'(ovf_err), 1);
        pulse_clr();
        chk(ovf_err === 1'b0, "R9 overflow cleared", int'(ovf_err), 0);
    endtask

    task automatic t_wrap();
        logic [CW-1:0] e1, e2;
        do_reset();
        tick_en = 1'b1;
        while (model_cnt != 8'd248) @(negedge clk);
        send_pulse(2, 4, e1);
        send_pulse(2, 4, e2);
        pop_chk(e1, "R2 before wrap");
        pop_chk(e2, "R2 after wrap");
        chk(dup_err === 1'b0 && ovf_err === 1'b0, "R2 wrap no flag",
            int'({dup_err, ovf_err}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_latency();
        t_order();
        t_wide();
        t_dup();
        t_overflow();
        t_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule